// File: doc/BRIEF.md
# Buffered Hexadecimal Display Scanner

This block drives a bank of eight seven-segment digits that share one segment bus. A local store of eight 4-bit registers holds the value for each digit. A write port loads any entry of the store, from switches or from tied-off constants. A 3-bit scan counter picks one digit at a time. The block then raises that digit's enable line and puts the digit's value on the segment bus as a hexadecimal glyph.

Segment and digit drive are active high, which suits a common-cathode display. An optional scan-enable input gates the counter. A slow strobe from an external prescaler can therefore set the refresh rate, and tying the input high scans on every clock. Both output buses are registered together. A glyph and its digit enable always change on the same edge, so no digit ever shows another digit's glyph.

Top module: `hex_scan_display`

## Requirements
- R1: On each rising clock edge with `scan_en` high and `rst` low, the scan counter advances by one and wraps from 7 to 0. The digits are therefore visited in the order 0,1,...,7,0.
- R2: `dig_o` is one-hot at all times after reset. When the scan count used for the registered output is n, only bit n is high.
- R3: `seg_o` bit 6 is segment g and bit 0 is segment a, and a 1 lights the segment. The glyphs for values 0 to 7 are 0111111, 0000110, 1011011, 1001111, 1100110, 1101101, 1111101 and 0000111.
- R4: The glyphs for values 8 to F are 1111111, 1101111, 1110111, 1111100, 0111001, 1011110, 1111001 and 1110001.
- R5: When `wr_en` is high on a rising edge, entry `wr_addr` of the store takes `wr_data` on that edge. Every other entry keeps its value.
- R6: The glyph shown for digit n is always decoded from store entry n, and never from the scan count itself.
- R7: A synchronous active-high `rst` clears the counter and all eight entries to zero. On the edge that samples `rst`, the outputs become `dig_o` = 00000001 and `seg_o` = 0111111.
- R8: The outputs are registered with one cycle of latency. After edge k, `dig_o` and `seg_o` both reflect the counter value and store contents held just before edge k. A write on edge k therefore shows up one edge later.
- R9: While `scan_en` is low the counter holds, and the same digit stays selected. Its glyph still follows writes to its entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Advance strobe for the scan counter |
| wr_en | input | 1 | Store write enable |
| wr_addr | input | 3 | Store entry to write |
| wr_data | input | 4 | Nibble to write |
| seg_o | output | 7 | Segment drive, g in bit 6 down to a in bit 0, active high |
| dig_o | output | 8 | One-hot digit enable, active high |

## Verification
A wrong counter state shows within one clock as a misplaced or repeated bit in `dig_o`. A corrupted store entry stays hidden until the scan next reaches that digit. It then shows as a wrong glyph within at most eight scan steps, so every sweep runs at least nine scan cycles after its writes. Glyph-table errors appear only when the bad value is displayed. The bench therefore loads patterns that together put all sixteen values on every digit position. The hold and reset cases also check that the store survives a stalled scan and is cleared by reset.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;

    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg_t;

    // Glyph for value zero, g..a with 1 = lit
    localparam seg_t GLYPH_ZERO = 7'b0111111;

endpackage

// File: rtl/hex_glyph.sv
module hex_glyph
    import hexscan_pkg::*;
(
    input  logic [3:0] value_i,
    output seg_t       seg_o
);

    always_comb begin
        unique case (value_i)
            4'h0: seg_o = GLYPH_ZERO;
            4'h1: seg_o = 7'b0000110;
            4'h2: seg_o = 7'b1011011;
            4'h3: seg_o = 7'b1001111;
            4'h4: seg_o = 7'b1100110;
            4'h5: seg_o = 7'b1101101;
            4'h6: seg_o = 7'b1111101;
            4'h7: seg_o = 7'b0000111;
            4'h8: seg_o = 7'b1111111;
            4'h9: seg_o = 7'b1101111;
            4'hA: seg_o = 7'b1110111;
            4'hB: seg_o = 7'b1111100;
            4'hC: seg_o = 7'b0111001;
            4'hD: seg_o = 7'b1011110;
            4'hE: seg_o = 7'b1111001;
            default: seg_o = 7'b1110001;
        endcase
    end

endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int DIGITS = 8,
    localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/digit_store.sv
module digit_store #(
    parameter int DIGITS = 8,
    parameter int NIB_W  = 4,
    localparam int ADDR_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NIB_W-1:0]  rd_data
);

    logic [NIB_W-1:0] ent_d [DIGITS];
    logic [NIB_W-1:0] ent_q [DIGITS];

    for (genvar i = 0; i < DIGITS; i++) begin : g_entry
        always_comb begin
            ent_d[i] = ent_q[i];
            if (wr_en && (wr_addr == ADDR_W'(i))) ent_d[i] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst) ent_q[i] <= '0;
            else     ent_q[i] <= ent_d[i];
        end
    end

    assign rd_data = ent_q[rd_addr];

endmodule

// File: rtl/hex_scan_display.sv
module hex_scan_display
    import hexscan_pkg::*;
#(
    parameter int DIGITS = 8,
    localparam int ADDR_W = (DIGITS > 1) ? $clog2(DIGITS) : 1,
    localparam int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    output logic [SEG_W-1:0]  seg_o,
    output logic [DIGITS-1:0] dig_o
);

    typedef struct packed {
        seg_t              seg;
        logic [DIGITS-1:0] dig;
    } drive_t;

    logic [ADDR_W-1:0] scan_cnt;
    logic [NIB_W-1:0]  cur_nib;
    seg_t              cur_seg;
    drive_t            drv_d, drv_q;

    scan_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .adv_i (scan_en),
        .cnt_o (scan_cnt)
    );

    digit_store #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (scan_cnt),
        .rd_data (cur_nib)
    );

    hex_glyph u_glyph (
        .value_i (cur_nib),
        .seg_o   (cur_seg)
    );

    always_comb begin
        drv_d.seg = cur_seg;
        drv_d.dig = DIGITS'(1) << scan_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q.seg <= GLYPH_ZERO;
            drv_q.dig <= DIGITS'(1);
        end else begin
            drv_q <= drv_d;
        end
    end

    assign seg_o = drv_q.seg;
    assign dig_o = drv_q.dig;

endmodule

// File: rtl/hex_scan_checker.sv
module hex_scan_checker #(
    parameter int DIGITS = 8,
    localparam int ADDR_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_en,
    input logic [6:0]        seg_o,
    input logic [DIGITS-1:0] dig_o,
    input logic [ADDR_W-1:0] cnt
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DIGITS - 1);

    assert_scan_advance_R1: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1));

    assert_dig_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(dig_o) == 1);

    assert_reset_state_R7: assert property (@(posedge clk)
        rst |=> (dig_o == DIGITS'(1)) && (seg_o == 7'b0111111));

    assert_dig_lags_count_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> dig_o[$past(cnt)]);

    assert_scan_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(cnt));

endmodule

bind hex_scan_display hex_scan_checker #(.DIGITS(DIGITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scan_en (scan_en),
    .seg_o   (seg_o),
    .dig_o   (dig_o),
    .cnt     (scan_cnt)
);

// File: tb/sim_hex_scan_display.sv
module sim_hex_scan_display;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [6:0] seg_o;
    logic [7:0] dig_o;

    int checks = 0;
    int errors = 0;

    logic [6:0] glyph [16] = '{7'b0111111, 7'b0000110, 7'b1011011, 7'b1001111,
                               7'b1100110, 7'b1101101, 7'b1111101, 7'b0000111,
                               7'b1111111, 7'b1101111, 7'b1110111, 7'b1111100,
                               7'b0111001, 7'b1011110, 7'b1111001, 7'b1110001};

    logic [2:0] m_cnt;
    logic [3:0] m_buf [8];
    logic [3:0] exp_val;
    logic [6:0] exp_seg;
    logic [7:0] exp_dig;

    always #2 clk = ~clk;

    hex_scan_display u0 (
        .clk(clk), .rst(rst), .scan_en(scan_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .seg_o(seg_o), .dig_o(dig_o)
    );

    task automatic fail_line(string req, string what, logic [7:0] act, logic [7:0] exp);
        errors++;
        $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    endtask

    // One clock: model the edge from the requirements, then compare at negedge.
    task automatic cycle(string req);
        @(posedge clk);
        #1;
        if (rst) begin
            m_cnt = '0;
            for (int i = 0; i < 8; i++) m_buf[i] = '0;
            exp_val = 4'h0;
            exp_dig = 8'b0000_0001;
        end else begin
            exp_val = m_buf[m_cnt];
            exp_dig = 8'(1) << m_cnt;
            if (scan_en) m_cnt = m_cnt + 3'd1;
            if (wr_en) m_buf[wr_addr] = wr_data;
        end
        exp_seg = glyph[exp_val];
        @(negedge clk);
        checks++;
        if (dig_o !== exp_dig) fail_line({req, " R1 R2"}, "dig_o", dig_o, exp_dig);
        checks++;
        if (seg_o !== exp_seg)
            fail_line({req, (exp_val < 8) ? " R3" : " R4"}, "seg_o", {1'b0, seg_o}, {1'b0, exp_seg});
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_cnt = '0;
        for (int i = 0; i < 8; i++) m_buf[i] = '0;
        // R7: reset state
        rst = 1'b1;
        for (int k = 0; k < 3; k++) cycle("R7");
        rst = 1'b0;
        scan_en = 1'b1;
        for (int k = 0; k < 9; k++) cycle("R7");

        // R5/R8: write each entry with its own index while scanning
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wr_addr = 3'(i); wr_data = 4'(i);
            cycle("R5 R8");
        end
        wr_en = 1'b0;
        for (int k = 0; k < 9; k++) cycle("R6");

        // R6 R3 R4: sweep patterns so every value lands on every digit
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < 8; i++) begin
                wr_en = 1'b1; wr_addr = 3'(7 - i); wr_data = 4'(i * 3 + p);
                cycle("R5");
            end
            wr_en = 1'b0;
            for (int k = 0; k < 9; k++) cycle("R6");
        end

        // R9: hold the scan, write the held digit and others
        scan_en = 1'b0;
        for (int k = 0; k < 3; k++) cycle("R9");
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wr_addr = 3'(i); wr_data = 4'(15 - i);
            cycle("R9");
            wr_en = 1'b0;
            cycle("R9 R8");
        end
        scan_en = 1'b1;
        for (int k = 0; k < 9; k++) cycle("R5 R9");

        // R1: strobed scan, advancing every other cycle
        for (int k = 0; k < 20; k++) begin
            scan_en = k[0];
            cycle("R1");
        end
        scan_en = 1'b1;

        // R7: reset in mid-run clears the store
        rst = 1'b1;
        cycle("R7");
        rst = 1'b0;
        for (int k = 0; k < 10; k++) cycle("R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule